// File: doc/BRIEF.md
# Token-Bucket Request Rate Limiter

This block limits how often single-cycle requests are allowed through. It holds a bucket of tokens, up to a capacity chosen at run time. A free-running timer adds one token every refill interval, and that interval is also chosen at run time. A request is granted when a token can be spent in its own cycle. Otherwise it is denied. The grant and deny indications are combinational, so logic upstream learns the decision in the same cycle it raises the request.

The capacity and the interval are held constant while the block is out of reset, and a new setting takes effect through a reset. When a refill and a request fall in the same cycle, the refill is counted first. An empty bucket can therefore grant a request on a refill cycle, and its count is still zero afterwards. Reset is synchronous and active-high, and the bucket leaves reset full.

Top module: `req_token_limiter`

## Requirements
- R1: While `rst` is 1, `grant` and `deny` are 0. On the edge that ends a reset cycle, the token count is loaded with `cap_cfg` and the refill timer returns to its starting phase.
- R2: Counting the first cycle with `rst` at 0 as cycle 1, refills occur on cycles N, 2N, 3N and so on, where N is `interval_cfg`. With N equal to 1, every cycle is a refill cycle.
- R3: A refill raises the token count by one when the count is below `cap_cfg`.
- R4: A refill on a full bucket leaves the count at `cap_cfg`, and the timer keeps its schedule while the bucket is full.
- R5: When `req_in` is 0, `grant` and `deny` are both 0.
- R6: A request is granted when the token count after any same-cycle refill is at least 1. A granted request removes exactly one token.
- R7: A request is denied when no token is available after any same-cycle refill. A denied request leaves the token count unchanged.
- R8: When the bucket is empty and a refill and a request arrive in the same cycle, the request is granted and the count stays at 0.
- R9: `grant` and `deny` depend on the current state and `req_in` in the same cycle, with no register stage in between.
- R10: `grant` and `deny` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active-high |
| cap_cfg | input | 5 | Bucket capacity, legal range 1 to 16 |
| interval_cfg | input | 9 | Refill interval in cycles, legal range 1 to 256 |
| req_in | input | 1 | Single-cycle request strobe |
| grant | output | 1 | Request in this cycle is accepted |
| deny | output | 1 | Request in this cycle is refused |

## Verification
Some properties can be checked every cycle, and the assertions check them:
- `grant` and `deny` are never both high.
- Both outputs stay low when there is no request.
- The token count never exceeds capacity.
- The timer stays within its reload range.
- A denial leaves the count unchanged.
- A grant without a refill lowers the count by one.

Other behaviour depends on timing over many cycles, and only the bench scenarios can show it:
- the exact cycle of the first refill after reset;
- saturation on a full bucket while the timer keeps its schedule;
- the grant of an empty bucket on a refill cycle;
- recovery from a reset in the middle of operation.

The bench covers these by comparing the outputs every cycle against a cycle-level model.

// File: rtl/req_token_limiter.sv
module req_token_limiter #(
  parameter int CAP_W = 5,
  parameter int PER_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAP_W-1:0] cap_cfg,
  input  logic [PER_W-1:0] interval_cfg,
  input  logic             req_in,
  output logic             grant,
  output logic             deny
);
  localparam int TMR_W = PER_W - 1;

  logic [CAP_W-1:0] tokens;
  logic [TMR_W-1:0] tmr;
  logic [PER_W-1:0] reload_full;
  logic [TMR_W-1:0] reload;
  logic             refill;
  logic [CAP_W-1:0] avail;

  assign reload_full = interval_cfg - PER_W'(1);
  assign reload      = reload_full[TMR_W-1:0];
  assign refill      = !rst && (tmr == '0);
  assign avail       = (refill && tokens < cap_cfg) ? tokens + CAP_W'(1) : tokens;
  assign grant       = !rst && req_in && (avail != '0);
  assign deny        = !rst && req_in && (avail == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tokens <= cap_cfg;
      tmr    <= reload;
    end else begin
      tokens <= grant ? avail - CAP_W'(1) : avail;
      tmr    <= refill ? reload : tmr - TMR_W'(1);
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(grant && deny)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !req_in |-> (!grant && !deny)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) tokens <= cap_cfg); // R4
  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst) {1'b0, tmr} <= reload_full); // R2
  AST_DENY_HOLDS: assert property (@(posedge clk) disable iff (rst) deny |=> tokens == $past(tokens)); // R7
  AST_GRANT_SPENDS: assert property (@(posedge clk) disable iff (rst)
    (grant && !refill) |=> tokens == $past(tokens) - CAP_W'(1)); // R6
endmodule

// File: tb/req_token_limiter_tb_top.sv
module req_token_limiter_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] cap_cfg;
  logic [8:0] interval_cfg;
  logic       req_in;
  logic       grant, deny;

  int n_chk = 0, n_bad = 0;
  int m_cnt, m_tmr, n_cnt, n_tmr;
  bit done = 0;

  always #2.5 clk = ~clk;

  req_token_limiter dut_i (
    .clk(clk), .rst(rst), .cap_cfg(cap_cfg), .interval_cfg(interval_cfg),
    .req_in(req_in), .grant(grant), .deny(deny)
  );

  function automatic string pick_tag(bit r, bit q, bit rf, int c, int cap);
    if (r) return "R1";
    if (!q) return "R5";
    if (rf && c == 0) return "R8";
    if (rf && c == cap) return "R4";
    if (rf) return "R3";
    if (c > 0) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {grant,deny} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, advance model at posedge
  task automatic step(bit r, bit q, string force_tag = "");
    bit rf, eg;
    int eff;
    string tag;
    @(negedge clk);
    rst = r; req_in = q;
    #1;
    rf  = !r && m_tmr == 0;
    eff = (rf && m_cnt < int'(cap_cfg)) ? m_cnt + 1 : m_cnt;
    eg  = !r && q && eff > 0;
    tag = (force_tag != "") ? force_tag : pick_tag(r, q, rf, m_cnt, int'(cap_cfg));
    check(tag, {grant, deny}, {eg, !r && q && !eg});
    check("R10", {1'b0, grant && deny}, 2'b00);
    if (r) begin
      n_cnt = int'(cap_cfg);
      n_tmr = int'(interval_cfg) - 1;
    end else begin
      n_cnt = eg ? eff - 1 : eff;
      n_tmr = rf ? int'(interval_cfg) - 1 : m_tmr - 1;
    end
    @(posedge clk);
    m_cnt = n_cnt; m_tmr = n_tmr;
  endtask

  task automatic configure(int cap, int per);
    @(negedge clk);
    rst = 1'b1; req_in = 1'b0;
    cap_cfg = 5'(cap); interval_cfg = 9'(per);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic run_random(int cycles, int req_pct, int rst_pml);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 1000) < rst_pml, ($urandom % 100) < req_pct);
  endtask

  initial begin
    rst = 1'b1; req_in = 1'b0; cap_cfg = 5'd1; interval_cfg = 9'd1;
    m_cnt = 0; m_tmr = 0;
    void'($urandom(32'd4711));

    // R2: capacity 1, interval 5: grant on cycle 1, deny on cycles 2..4, grant on cycle 5 (refill)
    configure(1, 5);
    step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");

    // R9: decision seen in the same cycle as the request
    step(1'b0, 1'b1, "R9");

    // capacity 16, interval 256: drain with a continuous request stream
    configure(16, 256);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1);

    // capacity 1, interval 1: refill every cycle, continuous stream always granted
    configure(1, 1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1);

    // full bucket idling, then an empty bucket meets a refill (R4, R8)
    configure(2, 3);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);

    // capacity 16, interval 1, and capacity 1, interval 256
    configure(16, 1);
    run_random(200, 90, 0);
    configure(1, 256);
    run_random(600, 30, 0);

    // random configurations with mid-operation reset
    for (int k = 0; k < 20; k++) begin
      configure(1 + ($urandom % 16), 1 + ($urandom % 256));
      run_random(500, 20 + ($urandom % 80), 3);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule